// File: doc/BRIEF.md
# Unsigned Fixed-Point Reciprocal Estimate

The block takes a 32-bit unsigned word read as a fraction in [0, 1) and returns an 8-bit-accurate estimate of its reciprocal, also as a 32-bit fixed-point word. When the top bit of the operand is set, the operand is treated as a value in [0.5, 1). The nine bits from the top form a table index, and a rounded quotient produces a 9-bit estimate in [256, 511]. The output keeps its top bit set and carries the eight lower estimate bits directly below it. All bits below those are zero.

An operand whose top bit is clear lies outside the normalized range. The result then saturates to all ones. There are no exponents, flags or refinement steps. A word is presented with a valid strobe, and its result appears on the output register one clock later with its own valid strobe. When no new word is presented, the output register keeps its value.

Top module: `recip_u32_est`

## Requirements
- R1: While reset is asserted and after it is released, before any valid input, out_valid_o is 0 and out_data_o is 0x00000000.
- R2: out_valid_o is high in the cycle after in_valid_i was sampled high and low in the cycle after it was sampled low (one-cycle latency).
- R3: A valid input with bit 31 clear produces out_data_o = 0xFFFFFFFF.
- R4: A valid input with bit 31 set produces an output with bit 31 set and bits [22:0] all zero.
- R5: For a valid input with bit 31 set, let q = 256 + in[30:23] and s = floor(256 / ((q + 0.5) / 512) + 0.5). Then out[30:23] = s - 256.
- R6: Input bits [22:0] have no effect on the result.
- R7: out_data_o holds its previous value in every cycle after in_valid_i was sampled low, whatever in_data_i carries.
- R8: The range ends map as follows: input 0x80000000 gives 0xFF800000 (s = 511), and input 0xFF800000 gives 0x80000000 (s = 256).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid_i | input | 1 | Operand strobe |
| in_data_i | input | 32 | Operand, unsigned fraction |
| out_valid_o | output | 1 | Result strobe, one cycle after in_valid_i |
| out_data_o | output | 32 | Reciprocal estimate or saturation word |

## Verification
The block keeps only two pieces of state, the result word and its strobe. Any corruption therefore shows at the ports in the first cycle after the operand was accepted. A wrong divider stage shows as a wrong estimate byte for specific index values, so all 256 indices are compared against a real-valued model. A broken enable shows as an output word that changes during idle cycles. A wrong saturation decode shows as an output word that is not all ones for an operand with the top bit clear, or as all ones for one with the top bit set.

// File: rtl/recip_est_pkg.sv
package recip_est_pkg;

  localparam int unsigned RE_DATA_W = 32;
  localparam int unsigned RE_IDX_W  = 8;
  localparam int unsigned RE_EST_W  = 8;

  typedef struct packed {
    logic                saturate;
    logic [RE_IDX_W-1:0] index;
  } recip_operand_t;

endpackage

// File: rtl/recip_rst_sync.sv
module recip_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/recip_seed_div.sv
module recip_seed_div #(
  parameter int unsigned IDX_W = 8,
  parameter int unsigned EST_W = 8
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic [EST_W-1:0] est_o
);

  // s = floor((2^(EST_W+IDX_W+3) + d) / (2d)), d = 2q+1, q = 2^IDX_W + idx
  localparam int unsigned DEN_W = IDX_W + 3;
  localparam int unsigned NUM_W = EST_W + IDX_W + 4;
  localparam int unsigned QUO_W = EST_W + 2;
  localparam int unsigned WRK_W = NUM_W + QUO_W;

  logic [IDX_W+1:0] odd_w;
  logic [DEN_W-1:0] den_w;
  logic [WRK_W-1:0] rem_w [0:QUO_W];
  logic [QUO_W-1:0] quo_w;
  logic             unused_quo;

  assign odd_w    = {1'b1, idx_i, 1'b1};
  assign den_w    = {odd_w, 1'b0};
  assign rem_w[0] = (WRK_W'(1) << (EST_W + IDX_W + 3)) + WRK_W'(odd_w);

  for (genvar g = 0; g < QUO_W; g++) begin : g_stage
    localparam int unsigned BITPOS = QUO_W - 1 - g;
    logic [WRK_W-1:0] trial_w;
    logic             take_w;

    always_comb begin
      trial_w      = WRK_W'(den_w) << BITPOS;
      take_w       = (rem_w[g] >= trial_w);
      rem_w[g+1]   = take_w ? (rem_w[g] - trial_w) : rem_w[g];
      quo_w[BITPOS] = take_w;
    end
  end

  assign est_o      = quo_w[EST_W-1:0];
  assign unused_quo = ^{quo_w[QUO_W-1:EST_W], rem_w[QUO_W]};

endmodule

// File: rtl/recip_out_reg.sv
module recip_out_reg #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] q_d;
  logic [WIDTH-1:0] q_q;

  always_comb begin
    q_d = q_q;
    if (en_i) begin
      q_d = d_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q <= '0;
    end else begin
      q_q <= q_d;
    end
  end

  assign q_o = q_q;

endmodule

// File: rtl/recip_u32_est.sv
module recip_u32_est
  import recip_est_pkg::*;
#(
  parameter int unsigned DATA_W = RE_DATA_W,
  parameter int unsigned IDX_W  = RE_IDX_W,
  parameter int unsigned EST_W  = RE_EST_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o
);

  localparam int unsigned TAIL_W = DATA_W - 1 - IDX_W;
  localparam int unsigned ZERO_W = DATA_W - 1 - EST_W;

  logic                rst_n_q;
  recip_operand_t      opnd_w;
  logic [EST_W-1:0]    est_w;
  logic [DATA_W-1:0]   word_d;
  logic                valid_d;
  logic                valid_q;
  logic                unused_tail;

  recip_rst_sync #(.STAGES(2)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_q)
  );

  always_comb begin
    opnd_w.saturate = ~in_data_i[DATA_W-1];
    opnd_w.index    = in_data_i[DATA_W-2 -: IDX_W];
  end

  assign unused_tail = ^in_data_i[TAIL_W-1:0];

  recip_seed_div #(.IDX_W(IDX_W), .EST_W(EST_W)) u_div (
    .idx_i (opnd_w.index),
    .est_o (est_w)
  );

  always_comb begin
    if (opnd_w.saturate) begin
      word_d = '1;
    end else begin
      word_d = {1'b1, est_w, {ZERO_W{1'b0}}};
    end
  end

  recip_out_reg #(.WIDTH(DATA_W)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_n_q),
    .en_i   (in_valid_i),
    .d_i    (word_d),
    .q_o    (out_data_o)
  );

  always_comb begin
    valid_d = in_valid_i;
  end

  always_ff @(posedge clk_i or negedge rst_n_q) begin
    if (!rst_n_q) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
    end
  end

  assign out_valid_o = valid_q;

endmodule

// File: rtl/recip_u32_est_chk.sv
module recip_u32_est_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned EST_W  = 8
) (
  input logic              clk_i,
  input logic              rst_n,
  input logic              in_valid_i,
  input logic [DATA_W-1:0] in_data_i,
  input logic              out_valid_o,
  input logic [DATA_W-1:0] out_data_o
);

  localparam int unsigned ZERO_W = DATA_W - 1 - EST_W;

  p_valid_rise_r2: assert property (@(posedge clk_i) disable iff (!rst_n)
    in_valid_i |=> out_valid_o);

  p_valid_fall_r2: assert property (@(posedge clk_i) disable iff (!rst_n)
    !in_valid_i |=> !out_valid_o);

  p_saturate_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    (in_valid_i && !in_data_i[DATA_W-1]) |=> (out_data_o == {DATA_W{1'b1}}));

  p_top_bit_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    (in_valid_i && in_data_i[DATA_W-1]) |=>
      (out_data_o[DATA_W-1] && (out_data_o[ZERO_W-1:0] == '0)));

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    !in_valid_i |=> $stable(out_data_o));

  p_low_end_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    (in_valid_i && (in_data_i[DATA_W-1 -: IDX_W+1] == {1'b1, {IDX_W{1'b0}}}))
      |=> (out_data_o[DATA_W-2 -: EST_W] == {EST_W{1'b1}}));

  p_high_end_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    (in_valid_i && (in_data_i[DATA_W-1 -: IDX_W+1] == {(IDX_W+1){1'b1}}))
      |=> (out_data_o[DATA_W-2 -: EST_W] == '0));

endmodule

bind recip_u32_est recip_u32_est_chk #(
  .DATA_W (DATA_W),
  .IDX_W  (IDX_W),
  .EST_W  (EST_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_n       (rst_n_q),
  .in_valid_i  (in_valid_i),
  .in_data_i   (in_data_i),
  .out_valid_o (out_valid_o),
  .out_data_o  (out_data_o)
);

// File: tb/recip_u32_est_test.sv
`timescale 1ns/1ps
module recip_u32_est_test;

  logic        clk;
  logic        rst_ni;
  logic        in_valid;
  logic [31:0] in_data;
  logic        out_valid;
  logic [31:0] out_data;

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  done     = 0;

  logic        exp_valid;
  logic [31:0] exp_data;
  string       exp_tag;

  recip_u32_est uut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid),
    .in_data_i   (in_data),
    .out_valid_o (out_valid),
    .out_data_o  (out_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [31:0] ref_word(input logic [31:0] x);
    real a, q, r;
    int  s;
    if (!x[31]) return 32'hFFFF_FFFF;
    a = real'(x) / 4294967296.0;
    q = $floor(a * 512.0);
    r = 256.0 / ((q + 0.5) / 512.0);
    s = $rtoi(r + 0.5);
    return 32'h8000_0000 | (32'(s - 256) << 23);
  endfunction

  always @(posedge clk) begin
    if (!rst_ni) begin
      exp_valid = 1'b0;
      exp_data  = 32'h0;
      exp_tag   = "R1";
    end else begin
      exp_valid = in_valid;
      if (in_valid) begin
        exp_data = ref_word(in_data);
        exp_tag  = in_data[31] ? "R5" : "R3";
      end else begin
        exp_tag  = "R7";
      end
    end
  end

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic compare_model();
    chk(out_valid === exp_valid, "R2", {31'b0, out_valid}, {31'b0, exp_valid});
    chk(out_data === exp_data, exp_tag, out_data, exp_data);
  endtask

  // drive now (at a falling edge), then compare one edge later
  task automatic step(input logic v, input logic [31:0] d);
    in_valid = v;
    in_data  = d;
    @(negedge clk);
    compare_model();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: actual %08h expected %08h", 32'h1, 32'h0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    logic [31:0] held;
    logic [31:0] first;
    rst_ni   = 1'b0;
    in_valid = 1'b0;
    in_data  = 32'h0;
    repeat (5) @(negedge clk);
    // R1: state while reset is asserted
    chk(out_valid === 1'b0 && out_data === 32'h0, "R1", out_data, 32'h0);
    rst_ni = 1'b1;
    repeat (4) step(1'b0, 32'hA5A5_A5A5);
    // R1: state after release, before any valid input
    chk(out_valid === 1'b0, "R1", {31'b0, out_valid}, 32'h0);
    chk(out_data === 32'h0, "R1", out_data, 32'h0);

    // R5: sweep all index values
    for (int k = 0; k < 256; k++) begin
      step(1'b1, 32'h8000_0000 | (32'(k) << 23));
      chk(out_data[22:0] === 23'h0 && out_data[31], "R4", out_data, ref_word(32'h8000_0000 | (32'(k) << 23)));
    end

    // R8: range ends
    step(1'b1, 32'h8000_0000);
    chk(out_data === 32'hFF80_0000, "R8", out_data, 32'hFF80_0000);
    step(1'b1, 32'hFF80_0000);
    chk(out_data === 32'h8000_0000, "R8", out_data, 32'h8000_0000);

    // R3: saturation patterns
    step(1'b1, 32'h0000_0000);
    chk(out_data === 32'hFFFF_FFFF, "R3", out_data, 32'hFFFF_FFFF);
    step(1'b1, 32'h7FFF_FFFF);
    chk(out_data === 32'hFFFF_FFFF, "R3", out_data, 32'hFFFF_FFFF);
    step(1'b1, 32'h1234_5678);
    chk(out_data === 32'hFFFF_FFFF, "R3", out_data, 32'hFFFF_FFFF);

    // R6: low bits have no effect
    for (int k = 0; k < 256; k += 17) begin
      step(1'b1, 32'h8000_0000 | (32'(k) << 23));
      first = out_data;
      step(1'b1, 32'h8000_0000 | (32'(k) << 23) | 32'h007F_FFFF);
      chk(out_data === first, "R6", out_data, first);
      step(1'b1, 32'h8000_0000 | (32'(k) << 23) | 32'h0015_A3C1);
      chk(out_data === first, "R6", out_data, first);
    end

    // R7: idle cycles hold the word while in_data changes
    step(1'b1, 32'hC000_0000);
    held = out_data;
    for (int k = 0; k < 6; k++) begin
      step(1'b0, 32'h0000_0001 << (k * 5));
      chk(out_data === held, "R7", out_data, held);
    end

    // R2, R3, R5: mixed traffic with toggling strobe
    lfsr = 32'hACE1_2468;
    for (int k = 0; k < 3000; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      step(lfsr[3] | lfsr[9], lfsr ^ {lfsr[15:0], lfsr[31:16]});
    end
    step(1'b0, 32'h0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule